// File: doc/BRIEF.md
# NAND Command Register Mode Logic

This block models the device side of a NAND flash command register together with the multiplexer that feeds the I/O bus during read cycles. Bytes on the I/O input are captured on the rising edge of the write-enable strobe. The capture happens only while the chip is selected and exactly one of the command-latch or address-latch lines is high. The captured commands decide which source feeds later read cycles: array data passed through from an input port, a live status byte, or a fixed identification sequence.

Array storage and the program and erase engines sit outside the block. They supply the busy flag, the pass/fail result and the array read byte as inputs. All pin inputs are sampled by a single clock that runs faster than the pin strobes. The output path is combinational from the current pin levels, so a selected byte appears as soon as the later of chip-enable and read-enable goes low.

Top module: `nand_cmd_reg`

## Requirements
- R1: After reset the block is in array-read mode, and the bus is idle (`ioOe` low, `ioOut` zero) until a read cycle starts.
- R2: Command 70h selects status mode. A read then drives `wpN` on bit 7, the inverse of `busyIn` (1 = ready) on bit 6 and `failIn` on bit 0. Bits 1 to 5 read as zero.
- R3: A byte is driven only while both `ceN` and `reN` are low. It appears in the same cycle as the later of the two falls.
- R4: In status mode, while a read cycle is held open, the driven byte follows changes of `busyIn`, `failIn` and `wpN` without any toggle of `reN` or `ceN`.
- R5: Status mode survives read cycles and address cycles. It is left only when a new command is written.
- R6: Command 00h or 50h selects array mode, in which reads drive `arrayData`.
- R7: Any command other than 00h, 50h, 70h or 90h selects a quiet mode, in which reads leave the bus idle.
- R8: Command 90h followed by one address cycle of 00h selects ID mode. The first read returns ADh, the read after one rising `reN` edge returns 76h, and later reads keep returning 76h.
- R9: Command 90h followed by an address byte other than 00h selects quiet mode.
- R10: ID mode survives reads until a new command is written. Entering ID mode again restarts the sequence at ADh.
- R11: A write strobe is ignored when `ceN` is high, or when `cleIn` and `aleIn` are both high or both low.
- R12: In every mode, `ioOe` is low and `ioOut` is zero whenever `ceN` or `reN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| cleIn | input | 1 | Command latch enable |
| aleIn | input | 1 | Address latch enable |
| weN | input | 1 | Write strobe, active low; capture on rising edge |
| reN | input | 1 | Read strobe, active low |
| wpN | input | 1 | Write-protect pin level, reported in status bit 7 |
| busyIn | input | 1 | Internal operation in progress |
| failIn | input | 1 | Last operation failed |
| ioIn | input | 8 | I/O bus input byte |
| arrayData | input | 8 | Byte from the page buffer for array reads |
| ioOut | output | 8 | I/O bus output byte, zero when not driving |
| ioOe | output | 1 | I/O bus output enable |

## Verification
The bench holds a read cycle open while it flips busy, fail and write-protect. A design that latched status only on the falling read edge would show a stale byte there. It walks the ID sequence past its end and re-enters ID mode. A pointer that wrapped, failed to saturate or was not cleared on entry would return the wrong byte. It issues write strobes with the chip deselected or with both latch lines high, which a careless decoder would accept as a mode change. It also checks that address cycles, and IDs whose address byte is not zero, neither leave status mode nor enter ID mode. Random command, address and read streams are checked against a bench model of the mode and pointer.

// File: rtl/nandcmd_pkg.sv
package nandcmd_pkg;

  localparam int BUS_W = 8;

  // opcodes and the ID trigger address
  localparam logic [BUS_W-1:0] OP_STATUS = 8'h70;
  localparam logic [BUS_W-1:0] OP_READ_A = 8'h00;
  localparam logic [BUS_W-1:0] OP_READ_C = 8'h50;
  localparam logic [BUS_W-1:0] OP_IDENT  = 8'h90;
  localparam logic [BUS_W-1:0] ID_TRIG   = 8'h00;

  // status bit positions
  localparam int ST_FAIL  = 0;
  localparam int ST_READY = 6;
  localparam int ST_WPN   = 7;

  typedef enum logic [2:0] {
    MODE_ARRAY,
    MODE_STATUS,
    MODE_IDPEND,
    MODE_ID,
    MODE_QUIET
  } rdMode_t;

  typedef struct packed {
    logic driveArray;
    logic driveStatus;
    logic driveId;
    logic idClear;
    logic idStep;
  } nandStrb_t;

endpackage

// File: rtl/nandcmd_ctrl.sv
module nandcmd_ctrl
  import nandcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             cleIn,
  input  logic             aleIn,
  input  logic             weN,
  input  logic             reN,
  input  logic [BUS_W-1:0] ioIn,
  output nandStrb_t        strb
);

  logic    weQ;
  logic    reQ;
  logic    weRise;
  logic    cmdCycle;
  logic    addrCycle;
  rdMode_t mode;
  rdMode_t modeNext;

  // a write strobe counts only with the chip selected and exactly one latch line high
  assign weRise    = !weQ && weN;
  assign cmdCycle  = weRise && !ceN && cleIn && !aleIn;
  assign addrCycle = weRise && !ceN && aleIn && !cleIn;

  always_comb begin
    modeNext = mode;
    if (cmdCycle) begin
      unique case (ioIn)
        OP_STATUS:            modeNext = MODE_STATUS;
        OP_READ_A, OP_READ_C: modeNext = MODE_ARRAY;
        OP_IDENT:             modeNext = MODE_IDPEND;
        default:              modeNext = MODE_QUIET;
      endcase
    end else if (addrCycle && mode == MODE_IDPEND) begin
      modeNext = (ioIn == ID_TRIG) ? MODE_ID : MODE_QUIET;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ  <= 1'b1;
      reQ  <= 1'b1;
      mode <= MODE_ARRAY;
    end else begin
      weQ  <= weN;
      reQ  <= reN;
      mode <= modeNext;
    end
  end

  always_comb begin
    strb.driveArray  = (mode == MODE_ARRAY);
    strb.driveStatus = (mode == MODE_STATUS);
    strb.driveId     = (mode == MODE_ID);
    strb.idClear     = (mode == MODE_IDPEND) && (modeNext == MODE_ID);
    strb.idStep      = (mode == MODE_ID) && !reQ && reN && !ceN;
  end

endmodule

// File: rtl/nandcmd_dpath.sv
module nandcmd_dpath
  import nandcmd_pkg::*;
#(
  parameter int                      ID_COUNT = 2,
  parameter logic [ID_COUNT*BUS_W-1:0] ID_SEQ = 16'h76AD
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             reN,
  input  logic             wpN,
  input  logic             busyIn,
  input  logic             failIn,
  input  logic [BUS_W-1:0] arrayData,
  input  nandStrb_t        strb,
  output logic [BUS_W-1:0] ioOut,
  output logic             ioOe
);

  localparam int PTR_W = (ID_COUNT > 1) ? $clog2(ID_COUNT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ID_COUNT - 1);

  logic [PTR_W-1:0] idPtr;
  logic [BUS_W-1:0] idByte;
  logic [BUS_W-1:0] statusByte;
  logic [BUS_W-1:0] selByte;
  logic             readEn;

  // pointer saturates on the last ID byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idPtr <= '0;
    end else if (strb.idClear) begin
      idPtr <= '0;
    end else if (strb.idStep && idPtr != PTR_LAST) begin
      idPtr <= idPtr + 1'b1;
    end
  end

  assign idByte = ID_SEQ[idPtr*BUS_W +: BUS_W];

  generate
    for (genvar b = 0; b < BUS_W; b++) begin : g_stat
      if (b == ST_FAIL) begin : g_fail
        assign statusByte[b] = failIn;
      end else if (b == ST_READY) begin : g_rdy
        assign statusByte[b] = !busyIn;
      end else if (b == ST_WPN) begin : g_wp
        assign statusByte[b] = wpN;
      end else begin : g_zero
        assign statusByte[b] = 1'b0;
      end
    end
  endgenerate

  assign readEn = !ceN && !reN;

  always_comb begin
    selByte = '0;
    if (strb.driveStatus)     selByte = statusByte;
    else if (strb.driveId)    selByte = idByte;
    else if (strb.driveArray) selByte = arrayData;
  end

  assign ioOe  = readEn && (strb.driveStatus || strb.driveId || strb.driveArray);
  assign ioOut = ioOe ? selByte : '0;

endmodule

// File: rtl/nand_cmd_reg.sv
module nand_cmd_reg
  import nandcmd_pkg::*;
#(
  parameter int                        ID_COUNT = 2,
  parameter logic [ID_COUNT*BUS_W-1:0] ID_SEQ   = 16'h76AD
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             cleIn,
  input  logic             aleIn,
  input  logic             weN,
  input  logic             reN,
  input  logic             wpN,
  input  logic             busyIn,
  input  logic             failIn,
  input  logic [BUS_W-1:0] ioIn,
  input  logic [BUS_W-1:0] arrayData,
  output logic [BUS_W-1:0] ioOut,
  output logic             ioOe
);

  nandStrb_t strb;

  nandcmd_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ceN   (ceN),
    .cleIn (cleIn),
    .aleIn (aleIn),
    .weN   (weN),
    .reN   (reN),
    .ioIn  (ioIn),
    .strb  (strb)
  );

  nandcmd_dpath #(
    .ID_COUNT (ID_COUNT),
    .ID_SEQ   (ID_SEQ)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .reN       (reN),
    .wpN       (wpN),
    .busyIn    (busyIn),
    .failIn    (failIn),
    .arrayData (arrayData),
    .strb      (strb),
    .ioOut     (ioOut),
    .ioOe      (ioOe)
  );

endmodule

// File: rtl/nandcmd_chk.sv
module nandcmd_chk
  import nandcmd_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             ceN,
  input logic             reN,
  input logic             wpN,
  input logic             busyIn,
  input logic             failIn,
  input logic [BUS_W-1:0] arrayData,
  input logic [BUS_W-1:0] ioOut,
  input logic             ioOe,
  input nandStrb_t        strb
);

  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || reN) |-> (!ioOe && ioOut == '0));

  assert_status_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveStatus && ioOe) |->
      (ioOut == {wpN, !busyIn, 5'b0, failIn}));

  assert_array_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveArray && ioOe) |-> (ioOut == arrayData));

  assert_id_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveId && ioOe) |-> (ioOut == 8'hAD || ioOut == 8'h76));

  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.driveArray, strb.driveStatus, strb.driveId}));

  assert_read_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !reN && (strb.driveArray || strb.driveStatus || strb.driveId)) |-> ioOe);

endmodule

bind nand_cmd_reg nandcmd_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceN       (ceN),
  .reN       (reN),
  .wpN       (wpN),
  .busyIn    (busyIn),
  .failIn    (failIn),
  .arrayData (arrayData),
  .ioOut     (ioOut),
  .ioOe      (ioOe),
  .strb      (strb)
);

// File: tb/nand_cmd_reg_test.sv
`timescale 1ns/1ps
module nand_cmd_reg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1, cleIn = 1'b0, aleIn = 1'b0, weN = 1'b1, reN = 1'b1;
  logic       wpN = 1'b1, busyIn = 1'b0, failIn = 1'b0;
  logic [7:0] ioIn = 8'h00, arrayData = 8'h5A;
  logic [7:0] ioOut;
  logic       ioOe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model: 0 array, 1 status, 2 ID pending, 3 ID, 4 quiet
  int mMode = 0;
  int mPtr  = 0;

  always #10 clk = ~clk;

  nand_cmd_reg uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn),
    .weN(weN), .reN(reN), .wpN(wpN), .busyIn(busyIn), .failIn(failIn),
    .ioIn(ioIn), .arrayData(arrayData), .ioOut(ioOut), .ioOe(ioOe)
  );

  function automatic logic [8:0] expBus(int md, int ptr, logic ce, logic re);
    if (ce || re) return 9'h000;
    case (md)
      0: return {1'b1, arrayData};
      1: return {1'b1, wpN, ~busyIn, 5'b0, failIn};
      3: return {1'b1, (ptr == 0) ? 8'hAD : 8'h76};
      default: return 9'h000;
    endcase
  endfunction

  task automatic check(string req, logic [8:0] exp);
    tests++;
    if ({ioOe, ioOut} !== exp) begin
      fails++;
      $display("FAIL %s: got oe=%0b io=%02h expected oe=%0b io=%02h",
               req, ioOe, ioOut, exp[8], exp[7:0]);
    end
  endtask

  task automatic modelWrite(logic cle, logic ale, logic ce, logic [7:0] d);
    if (ce || cle == ale) return;
    if (cle) begin
      case (d)
        8'h70:        mMode = 1;
        8'h00, 8'h50: mMode = 0;
        8'h90:        mMode = 2;
        default:      mMode = 4;
      endcase
    end else if (mMode == 2) begin
      mMode = (d == 8'h00) ? 3 : 4;
      mPtr  = 0;
    end
  endtask

  task automatic busWrite(logic cle, logic ale, logic ce, logic [7:0] d);
    @(negedge clk);
    ceN = ce; cleIn = cle; aleIn = ale; ioIn = d; weN = 1'b0;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    repeat (2) @(negedge clk);
    cleIn = 1'b0; aleIn = 1'b0; ceN = 1'b0;
    modelWrite(cle, ale, ce, d);
  endtask

  task automatic doRead(string req);
    @(negedge clk);
    reN = 1'b0;
    #2 check(req, expBus(mMode, mPtr, ceN, reN));
    @(negedge clk);
    reN = 1'b1;
    repeat (2) @(negedge clk);
    if (mMode == 3 && mPtr == 0) mPtr = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got running expected finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ceN  = 1'b0;
    @(negedge clk);
    #2 check("R1 idle after reset", 9'h000);
    doRead("R1 array after reset");

    busWrite(1, 0, 0, 8'h70);
    doRead("R2 status ready");
    // hold the read open and move the inputs
    @(negedge clk); reN = 1'b0;
    #2 check("R2 status open", {1'b1, 8'hC0});
    busyIn = 1'b1; #2 check("R4 busy live", {1'b1, 8'h80});
    failIn = 1'b1; #2 check("R4 fail live", {1'b1, 8'h81});
    wpN = 1'b0;    #2 check("R4 wp live", {1'b1, 8'h01});
    ceN = 1'b1;    #2 check("R12 ce high", 9'h000);
    ceN = 1'b0;    #2 check("R3 later fall", {1'b1, 8'h01});
    reN = 1'b1;    #2 check("R12 re high", 9'h000);
    busyIn = 1'b0; failIn = 1'b0; wpN = 1'b1;
    repeat (2) @(negedge clk);

    busWrite(0, 1, 0, 8'h00);
    doRead("R5 status after address");
    doRead("R5 status after read");
    busWrite(1, 0, 0, 8'h00);
    arrayData = 8'h3C;
    doRead("R6 array after 00h");
    busWrite(1, 0, 0, 8'h70);
    busWrite(1, 0, 0, 8'h50);
    doRead("R6 array after 50h");

    busWrite(1, 0, 0, 8'h90);
    busWrite(0, 1, 0, 8'h00);
    doRead("R8 first ID byte");
    doRead("R8 second ID byte");
    doRead("R8 ID holds");
    busWrite(1, 0, 0, 8'h70);
    doRead("R10 leave ID");
    busWrite(1, 0, 0, 8'h90);
    busWrite(0, 1, 0, 8'h00);
    doRead("R10 ID restarts");

    busWrite(1, 0, 0, 8'h90);
    busWrite(0, 1, 0, 8'h05);
    doRead("R9 bad ID address");
    busWrite(1, 0, 0, 8'h60);
    doRead("R7 quiet mode");

    busWrite(1, 0, 0, 8'h00);
    busWrite(1, 0, 1, 8'h70);
    doRead("R11 deselected write");
    busWrite(1, 1, 0, 8'h70);
    doRead("R11 both latch lines");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: begin
          int c;
          logic [7:0] cmd;
          c = $urandom % 6;
          case (c)
            0: cmd = 8'h00;
            1: cmd = 8'h50;
            2: cmd = 8'h70;
            3: cmd = 8'h90;
            4: cmd = 8'h60;
            default: cmd = 8'($urandom);
          endcase
          busWrite(1, 0, 0, cmd);
        end
        1: busWrite(0, 1, 0, ($urandom % 2) ? 8'h00 : 8'($urandom));
        2: begin
          busyIn = 1'($urandom); failIn = 1'($urandom); wpN = 1'($urandom);
          arrayData = 8'($urandom);
        end
        default: doRead("R3 random read");
      endcase
    end

    finishRun();
  end

endmodule